// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block sits beside the decode stage of an in-order integer pipeline. When a load issues, it looks at the instruction word that comes directly after the load. It decides whether that instruction reads the register the load is about to write. If it does, the pipeline must hold for one cycle. The block raises a registered stall pulse and adds one to a saturating count of interlocks.

The decision depends on the instruction format. The format is the two top bits of the word.
- Branch, sethi and call formats never read a register, so they never interlock.
- A floating-point operate word uses the register-register format with a marker value in bits 24:20. It reads no integer registers, so it never interlocks.
- Every other register-register word and every memory-format word is checked against its first source field.
- The second source field is checked as well, unless the immediate bit marks bits 4:0 as a constant.
- Register 0 always reads as zero, so a load into it cannot create a hazard.

Top module: `ilk_detector`

## Requirements
- R1: After a synchronous active-low reset, `stall` is 0 and `ilock_count` is 0.
- R2: When `nxt_instr[31:30]` is 2'b00 or 2'b01, no interlock is raised, even if its source fields equal `ld_dest`.
- R3: When `nxt_instr[31:30]` is 2'b10 and `nxt_instr[24:20]` is 5'h1A (floating-point operate), no interlock is raised, even if its source fields equal `ld_dest`.
- R4: When `nxt_instr[31:30]` is 2'b11 (any value of bits 24:20), or is 2'b10 with bits 24:20 not 5'h1A, an interlock is raised if `nxt_instr[18:14]` equals a non-zero `ld_dest`. This holds whatever the value of bit 13.
- R5: For the words covered by R4, when bits 18:14 differ from `ld_dest` and `nxt_instr[13]` is 1, no interlock is raised, even if bits 4:0 equal `ld_dest`.
- R6: For the words covered by R4, when bits 18:14 differ from `ld_dest`, `nxt_instr[13]` is 0 and `nxt_instr[4:0]` equals a non-zero `ld_dest`, an interlock is raised.
- R7: An `ld_dest` of 0 never raises an interlock.
- R8: No interlock is raised while `ld_valid` is 0.
- R9: `stall` is registered. It is 1 in the cycle that follows a clock edge at which an interlock was detected. After a single-cycle strobe it is 1 for exactly one cycle.
- R10: Each detected interlock adds exactly one to `ilock_count`, at the same clock edge that raises `stall`. In every other cycle the count holds its value.
- R11: `ilock_count` saturates at 2^CNT_W-1. Further interlocks leave it at that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load has issued and `nxt_instr` is the word after it |
| ld_dest | input | REG_W | Destination register number of the load |
| nxt_instr | input | 32 | Instruction word that follows the load |
| stall | output | 1 | Registered one-cycle interlock pulse |
| ilock_count | output | CNT_W | Saturating count of interlocks |

## Verification
The bench builds the block with CNT_W set to 3, so the counter saturates at 7. Its last few interlocks therefore run the count into the ceiling and then hold there, which would take far too many cycles at the default width. REG_W stays at 5, the width the field positions require. Every format class is offered a word whose fields match the load destination, so each "no interlock" outcome is shown against a word that would otherwise stall.

// File: rtl/ilk_pkg.sv
// Package: shared types and constants for the load-use interlock detector.
// Assumes 32-bit instruction words with the format in bits 31:30.
package ilk_pkg;

    // Format classes of the word that follows a load
    typedef enum logic [1:0] {
        CLS_CTRL = 2'd0,   // branch / sethi / call: reads no register
        CLS_FPOP = 2'd1,   // floating-point operate: reads no integer register
        CLS_INT  = 2'd2    // integer or memory format: reads source fields
    } instr_cls_e;

    // Two-bit major format codes
    localparam logic [1:0] FMT_BR   = 2'b00;
    localparam logic [1:0] FMT_CALL = 2'b01;
    localparam logic [1:0] FMT_ALU  = 2'b10;
    localparam logic [1:0] FMT_MEM  = 2'b11;

    // Marker in bits 24:20 that flags a floating-point operate word
    localparam logic [4:0] FPOP_MARK = 5'h1A;

    // Source fields pulled from the word, with use qualifiers
    typedef struct packed {
        logic [4:0] src_a;
        logic [4:0] src_b;
        logic       use_a;
        logic       use_b;
    } src_info_t;

endpackage

// File: rtl/ilk_decode.sv
// Module: ilk_decode
// Classifies the word after a load and extracts the register fields it reads.
// Assumes: the first source sits in bits 18:14, the second in bits 4:0, and
// bit 13 selects a constant in place of the second source. Purely combinational.
module ilk_decode
    import ilk_pkg::*;
(
    input  logic [31:0] instr,
    output instr_cls_e  cls,
    output src_info_t   src
);

    // Bits this block does not look at, gathered to document that
    logic unused_bits;
    assign unused_bits = ^{instr[29:25], instr[19], instr[12:5]};

    // Pick the format class from the major code and the float marker
    always_comb begin
        unique case (instr[31:30])
            FMT_BR, FMT_CALL: cls = CLS_CTRL;
            FMT_ALU:          cls = (instr[24:20] == FPOP_MARK) ? CLS_FPOP : CLS_INT;
            default:          cls = CLS_INT;
        endcase
    end

    // Extract the source fields and say which ones are really read
    always_comb begin
        src.src_a = instr[18:14];
        src.src_b = instr[4:0];
        src.use_a = (cls == CLS_INT);
        src.use_b = (cls == CLS_INT) && !instr[13];
    end

endmodule

// File: rtl/ilk_match.sv
// Module: ilk_match
// Compares the load destination against the source fields that are read.
// Assumes: register 0 is constant zero and never carries a hazard. Combinational.
module ilk_match
    import ilk_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             ld_valid,
    input  logic [REG_W-1:0] ld_dest,
    input  src_info_t        src,
    output logic             hit
);

    logic dest_live;
    logic a_eq;
    logic b_eq;

    // Qualify the destination and compare it against each source field
    always_comb begin
        dest_live = ld_valid && (ld_dest != '0);
        a_eq      = src.use_a && (src.src_a == ld_dest);
        b_eq      = src.use_b && (src.src_b == ld_dest);
        hit       = dest_live && (a_eq || b_eq);
    end

endmodule

// File: rtl/ilk_sat_counter.sv
// Module: ilk_sat_counter
// Counts interlock events and stops at the all-ones value.
// Assumes: a synchronous active-low reset and at most one event per cycle.
module ilk_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Add one per event unless the count is already at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && (count != CNT_MAX))
            count <= count + 1'b1;
    end

endmodule

// File: rtl/ilk_detector.sv
// Module: ilk_detector (top)
// Load-use interlock detector. It registers a one-cycle stall and counts the
// interlocks when the word after a load reads the load's destination register.
// Assumes: ld_valid marks the cycle in which nxt_instr follows a load, and
// REG_W matches the 5-bit source fields of the instruction word.
module ilk_detector
    import ilk_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [REG_W-1:0] ld_dest,
    input  logic [31:0]      nxt_instr,
    output logic             stall,
    output logic [CNT_W-1:0] ilock_count
);

    instr_cls_e cls;
    src_info_t  src;
    logic       hit;

    ilk_decode u_decode (
        .instr (nxt_instr),
        .cls   (cls),
        .src   (src)
    );

    ilk_match #(.REG_W(REG_W)) u_match (
        .ld_valid (ld_valid),
        .ld_dest  (ld_dest),
        .src      (src),
        .hit      (hit)
    );

    ilk_sat_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit),
        .count (ilock_count)
    );

    // Register the hazard so the stall appears for one cycle per detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            stall <= 1'b0;
        else
            stall <= hit;
    end

endmodule

// File: rtl/ilk_detector_chk.sv
// Module: ilk_detector_chk
// Assertion checker bound to ilk_detector. It watches only the ports.
// Assumes: the synchronous active-low reset is applied for at least one edge.
module ilk_detector_chk #(
    parameter int REG_W = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [REG_W-1:0] ld_dest,
    input logic [31:0]      nxt_instr,
    input logic             stall,
    input logic [CNT_W-1:0] ilock_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Control formats never stall (R2)
    assert_ctrl_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !nxt_instr[31]) |=> !stall);

    // Floating-point operate words never stall (R3)
    assert_fpop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && nxt_instr[31:30] == 2'b10 && nxt_instr[24:20] == 5'h1A) |=> !stall);

    // An immediate word whose first source differs does not stall (R5)
    assert_imm_ignores_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_instr[13] && nxt_instr[18:14] != ld_dest) |=> !stall);

    // A destination of register 0 never stalls (R7)
    assert_dest_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_dest == '0) |=> !stall);

    // A stall needs a valid load at the previous edge (R8, R9)
    assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(ld_valid));

    // The count moves by at most one per cycle (R10)
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ilock_count == $past(ilock_count)) ||
        (ilock_count == CNT_W'($past(ilock_count) + 1'b1)));

    // A rise of the count comes with a stall (R10)
    assert_count_with_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ilock_count != $past(ilock_count)) |-> stall);

    // The count stays at its ceiling once there (R11)
    assert_count_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ilock_count) == CNT_MAX) |-> (ilock_count == CNT_MAX));

endmodule

bind ilk_detector ilk_detector_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_dest     (ld_dest),
    .nxt_instr   (nxt_instr),
    .stall       (stall),
    .ilock_count (ilock_count)
);

// File: tb/ilk_detector_tb_top.sv
// Directed bench for ilk_detector, built with a 3-bit counter.
module ilk_detector_tb_top;

    localparam int REG_W = 5;
    localparam int CNT_W = 3;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_valid = 1'b0;
    logic [REG_W-1:0] ld_dest = '0;
    logic [31:0]      nxt_instr = '0;
    logic             stall;
    logic [CNT_W-1:0] ilock_count;

    int checks = 0;
    int fails = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    ilk_detector #(.REG_W(REG_W), .CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .ld_dest     (ld_dest),
        .nxt_instr   (nxt_instr),
        .stall       (stall),
        .ilock_count (ilock_count)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Build a word from the fields the detector reads
    function automatic logic [31:0] mk(input logic [1:0] fmt, input logic [4:0] mark,
                                       input logic [4:0] a, input logic imm,
                                       input logic [4:0] b);
        logic [31:0] w;
        w = 32'h0;
        w[31:30] = fmt;
        w[24:20] = mark;
        w[18:14] = a;
        w[13]    = imm;
        w[4:0]   = b;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one strobe, check the stall pulse, the count and the pulse end
    task automatic probe(input logic v, input logic [4:0] d, input logic [31:0] w,
                         input bit exp_stall, input string req);
        @(negedge clk);
        ld_valid  = v;
        ld_dest   = d;
        nxt_instr = w;
        @(negedge clk);
        if (exp_stall && exp_cnt < MAXC) exp_cnt++;
        check(stall == exp_stall, req, int'(stall), int'(exp_stall));
        check(int'(ilock_count) == exp_cnt, {req, "/R10"}, int'(ilock_count), exp_cnt);
        ld_valid = 1'b0;
        @(negedge clk);
        check(stall == 1'b0, {req, "/R9 one cycle"}, int'(stall), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(stall == 1'b0, "R1 stall", int'(stall), 0);
        check(ilock_count == '0, "R1 count", int'(ilock_count), 0);
        exp_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic t_ctrl_formats();
        probe(1'b1, 5'd7, mk(2'b00, 5'h00, 5'd7, 1'b0, 5'd7), 1'b0, "R2 fmt00");
        probe(1'b1, 5'd7, mk(2'b01, 5'h00, 5'd7, 1'b0, 5'd7), 1'b0, "R2 fmt01");
    endtask

    task automatic t_fpop();
        probe(1'b1, 5'd9, mk(2'b10, 5'h1A, 5'd9, 1'b0, 5'd9), 1'b0, "R3 fpop");
    endtask

    task automatic t_first_source();
        probe(1'b1, 5'd9, mk(2'b10, 5'h00, 5'd9, 1'b0, 5'd1), 1'b1, "R4 alu a");
        probe(1'b1, 5'd9, mk(2'b11, 5'h1A, 5'd9, 1'b0, 5'd1), 1'b1, "R4 mem a");
        probe(1'b1, 5'd4, mk(2'b11, 5'h00, 5'd4, 1'b1, 5'd2), 1'b1, "R4 imm a");
    endtask

    task automatic t_second_source();
        probe(1'b1, 5'd12, mk(2'b11, 5'h00, 5'd3, 1'b1, 5'd12), 1'b0, "R5 imm b");
        probe(1'b1, 5'd12, mk(2'b10, 5'h05, 5'd3, 1'b0, 5'd12), 1'b1, "R6 reg b");
    endtask

    task automatic t_quiet();
        probe(1'b1, 5'd0, mk(2'b10, 5'h00, 5'd0, 1'b0, 5'd0), 1'b0, "R7 dest0");
        probe(1'b0, 5'd6, mk(2'b11, 5'h00, 5'd6, 1'b0, 5'd6), 1'b0, "R8 no valid");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 5; i++)
            probe(1'b1, 5'd21, mk(2'b11, 5'h00, 5'd21, 1'b0, 5'd0), 1'b1, "R11 sat");
        check(int'(ilock_count) == MAXC, "R11 ceiling", int'(ilock_count), MAXC);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ctrl_formats();
        t_fpop();
        t_first_source();
        t_second_source();
        t_quiet();
        t_saturate();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule